// File: doc/BRIEF.md
# Multi-format serial audio port

The port sits between a stereo converter datapath and an external serial audio link on which another device supplies the bit clock and the word-select line. On every bit clock it shifts one bit of playback data in and one bit of capture data out. Left and right words take turns on each data line, and the word-select level tells which channel a slot belongs to. Received words come out as parallel left and right samples, each with a one-cycle strobe. Transmitted words are taken from two parallel inputs at the start of each slot.

A 3-bit format input selects the framing. The framing can be I2S, MSB-justified or LSB-justified. In three combined codes, an MSB-justified output runs together with an LSB-justified input of 16, 18 or 20 bits. In LSB-justified framing the word ends at the slot boundary, so the transmitter must know where the next word-select edge falls before it happens. It predicts the edge from the measured length of the previous slot. The clock edges themselves are generated outside the port, and so is all sample processing.

Top module: `audio_serial_port`

## Requirements
- R1: `fmt_i` selects framing per direction (transmit/receive): 0 = I2S/I2S; 1, 2, 3 = LSB-justified in both directions with 16, 18, 20 bits; 4 = MSB-justified/MSB-justified; 5, 6, 7 = MSB-justified transmit with LSB-justified receive of 16, 18, 20 bits.
- R2: I2S receive: `ws_i` low marks the left slot. The MSB is the bit sampled one bit clock after the word-select change. The next 20 bits form the word.
- R3: LSB-justified receive: `ws_i` high marks the left slot. The word is the last N bits sampled before the next word-select change. Earlier bits in the slot have no effect, and bit N-1 is copied into bits 19..N.
- R4: MSB-justified receive: `ws_i` high marks the left slot. The MSB is the bit sampled on the same rising edge that sees the word-select change, and the first 20 bits form the word.
- R5: I2S and MSB-justified transmit: the word is placed with the same alignment and channel rule as in R2 and R4, and the slot bits after it are 0.
- R6: LSB-justified transmit: the word's bit 0 is the last bit before the slot ends, bits N-1..0 run MSB first, and the bits before them carry bit N-1.
- R7: In codes 5 to 7, both directions run at the same time with their own framings under one word-select line.
- R8: Each captured word raises exactly one one-cycle strobe for its channel. The left and right strobes never fire together, and a sample output changes only in a cycle where its strobe is high.
- R9: After reset all outputs are 0. No strobe appears before the first word-select change, and in LSB-justified receive none appears before the second. `sdo_o` stays 0 until two changes have fixed the slot length.
- R10: `sdi_i` and `ws_i` are sampled on the rising bit-clock edge, and `sdo_o` changes only on the falling edge.
- R11: A transmitted slot carries the parallel input value present at the falling edge before the slot starts. Changes to that input during the slot do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | bit clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| fmt_i | input | 3 | framing select (see R1) |
| ws_i | input | 1 | word select |
| sdi_i | input | 1 | serial data in |
| tx_left_i | input | SAMPLE_W | left word to transmit |
| tx_right_i | input | SAMPLE_W | right word to transmit |
| sdo_o | output | 1 | serial data out |
| rx_left_o | output | SAMPLE_W | last received left word |
| rx_right_o | output | SAMPLE_W | last received right word |
| rx_left_vld_o | output | 1 | left word strobe |
| rx_right_vld_o | output | 1 | right word strobe |

## Verification
All eight format codes are run with slot lengths of 20, 24 and 32 bits, and the received words take varied sign bits. A wrong channel rule, a one-bit alignment error or a dropped sign extension therefore shows up as a different captured value. Toggling filler bits outside the word region separates a receiver that ignores them from one that shifts them in. The parallel transmit inputs change in the middle of each slot, which shows whether the word is latched at the predicted slot start. A separate run with a single word-select change confirms that the output stays quiet until the slot length is known.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    FRM_I2S = 2'd0,
    FRM_MSB = 2'd1,
    FRM_LSB = 2'd2
  } frame_e;

  typedef struct packed {
    frame_e     tx;
    frame_e     rx;
    logic [4:0] lsb_bits;
  } port_cfg_t;

  function automatic port_cfg_t decode_fmt(input logic [2:0] f);
    port_cfg_t c;
    c.tx       = FRM_MSB;
    c.rx       = FRM_LSB;
    c.lsb_bits = 5'd20;
    case (f)
      3'd0: begin c.tx = FRM_I2S; c.rx = FRM_I2S; end
      3'd1: begin c.tx = FRM_LSB; c.lsb_bits = 5'd16; end
      3'd2: begin c.tx = FRM_LSB; c.lsb_bits = 5'd18; end
      3'd3: begin c.tx = FRM_LSB; c.lsb_bits = 5'd20; end
      3'd4: begin c.rx = FRM_MSB; end
      3'd5: c.lsb_bits = 5'd16;
      3'd6: c.lsb_bits = 5'd18;
      default: c.lsb_bits = 5'd20;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asp_slot_tracker.sv
module asp_slot_tracker #(
  parameter int POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ws_i,
  output logic             ws_q_o,
  output logic             edge_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic [POS_W-1:0] last_pos_o,
  output logic             seen_one_o,
  output logic             locked_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic       primed;
  logic [1:0] edges;

  always_comb begin
    edge_o    = primed & (ws_i ^ ws_q_o);
    pos_nxt_o = edge_o ? '0 : ((pos_o == POS_MAX) ? POS_MAX : pos_o + 1'b1);
  end

  // pos: slot position of the bit sampled at the last rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed     <= 1'b0;
      ws_q_o     <= 1'b0;
      pos_o      <= POS_MAX;
      last_pos_o <= '0;
      edges      <= 2'd0;
    end else begin
      primed <= 1'b1;
      ws_q_o <= ws_i;
      pos_o  <= pos_nxt_o;
      if (edge_o) begin
        last_pos_o <= pos_o;
        if (edges != 2'd2) edges <= edges + 2'd1;
      end
    end
  end

  assign seen_one_o = (edges != 2'd0);
  assign locked_o   = (edges == 2'd2);

  a_r9_lock_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(edge_o));

endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int SW    = 20,
  parameter int POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_e           frame_i,
  input  logic [4:0]       nbits_i,
  input  logic             sdi_i,
  input  logic             ws_i,
  input  logic             ws_q_i,
  input  logic             edge_i,
  input  logic [POS_W-1:0] pos_nxt_i,
  input  logic             seen_one_i,
  output logic [SW-1:0]    left_o,
  output logic [SW-1:0]    right_o,
  output logic             left_vld_o,
  output logic             right_vld_o
);
  localparam int IW = $clog2(SW);

  logic [SW-1:0] sr;
  logic [SW-1:0] lsb_word, word;
  logic          done, is_left;

  always_comb begin
    for (int i = 0; i < SW; i++)
      lsb_word[i] = (i < int'(nbits_i)) ? sr[i] : sr[IW'(nbits_i) - IW'(1)];
    done    = 1'b0;
    is_left = 1'b0;
    word    = {sr[SW-2:0], sdi_i};
    case (frame_i)
      FRM_I2S: begin
        done    = (pos_nxt_i == POS_W'(SW));
        is_left = ~ws_i;
      end
      FRM_MSB: begin
        done    = (pos_nxt_i == POS_W'(SW - 1));
        is_left = ws_i;
      end
      default: begin
        // slot just ended; sr still holds its last bits
        done    = edge_i & seen_one_i;
        is_left = ws_q_i;
        word    = lsb_word;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr          <= '0;
      left_o      <= '0;
      right_o     <= '0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      sr          <= {sr[SW-2:0], sdi_i};
      left_vld_o  <= done & is_left;
      right_vld_o <= done & ~is_left;
      if (done && is_left)  left_o  <= word;
      if (done && !is_left) right_o <= word;
    end
  end

  a_r8_left_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |=> !left_vld_o);
  a_r8_left_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_o != $past(left_o)) |-> left_vld_o);
  a_r8_right_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (right_o != $past(right_o)) |-> right_vld_o);
  a_r3_lsb_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i == FRM_LSB && (left_vld_o || right_vld_o)) |-> $past(edge_i));

endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int SW    = 20,
  parameter int POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_e           frame_i,
  input  logic [4:0]       nbits_i,
  input  logic             ws_q_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] last_pos_i,
  input  logic             locked_i,
  input  logic [SW-1:0]    left_i,
  input  logic [SW-1:0]    right_i,
  output logic             sdo_o
);
  localparam int               IW      = $clog2(SW);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [SW-1:0]    word_q, cur;
  logic [POS_W-1:0] np, msb_idx, lsb_idx;
  logic             wrap, ws_pred, take_left;
  logic             msb_bit, lsb_bit, sign_bit, m_prev;

  // predict position and channel of the bit sampled at the next rising edge
  always_comb begin
    wrap      = locked_i && (pos_i == last_pos_i);
    np        = wrap ? '0 : ((pos_i == POS_MAX) ? POS_MAX : pos_i + 1'b1);
    ws_pred   = wrap ? ~ws_q_i : ws_q_i;
    take_left = (frame_i == FRM_I2S) ? ~ws_pred : ws_pred;
    cur       = (np == '0) ? (take_left ? left_i : right_i) : word_q;
    msb_idx   = POS_W'(SW - 1) - np;
    msb_bit   = (np < POS_W'(SW)) ? cur[msb_idx[IW-1:0]] : 1'b0;
    lsb_idx   = last_pos_i - np;
    sign_bit  = cur[IW'(nbits_i) - IW'(1)];
    lsb_bit   = (lsb_idx < POS_W'(nbits_i)) ? cur[lsb_idx[IW-1:0]] : sign_bit;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      m_prev <= 1'b0;
      sdo_o  <= 1'b0;
    end else begin
      if (np == '0) word_q <= cur;
      m_prev <= msb_bit;
      if (!locked_i)                sdo_o <= 1'b0;
      else if (frame_i == FRM_I2S)  sdo_o <= m_prev;  // MSB stream delayed one bit
      else if (frame_i == FRM_MSB)  sdo_o <= msb_bit;
      else                          sdo_o <= lsb_bit;
    end
  end

  a_r9_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> !sdo_o);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int MAX_SLOT = 64
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic [2:0]          fmt_i,
  input  logic                ws_i,
  input  logic                sdi_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                sdo_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic                rx_left_vld_o,
  output logic                rx_right_vld_o
);
  localparam int POS_W = $clog2(MAX_SLOT);

  port_cfg_t        cfg;
  logic             ws_q, ws_edge, seen_one, locked;
  logic [POS_W-1:0] pos, pos_nxt, last_pos;

  assign cfg = decode_fmt(fmt_i);

  asp_slot_tracker #(.POS_W(POS_W)) u_track (
    .clk_i      (bclk_i),
    .rst_ni     (rst_ni),
    .ws_i       (ws_i),
    .ws_q_o     (ws_q),
    .edge_o     (ws_edge),
    .pos_o      (pos),
    .pos_nxt_o  (pos_nxt),
    .last_pos_o (last_pos),
    .seen_one_o (seen_one),
    .locked_o   (locked)
  );

  asp_rx #(.SW(SAMPLE_W), .POS_W(POS_W)) u_rx (
    .clk_i       (bclk_i),
    .rst_ni      (rst_ni),
    .frame_i     (cfg.rx),
    .nbits_i     (cfg.lsb_bits),
    .sdi_i       (sdi_i),
    .ws_i        (ws_i),
    .ws_q_i      (ws_q),
    .edge_i      (ws_edge),
    .pos_nxt_i   (pos_nxt),
    .seen_one_i  (seen_one),
    .left_o      (rx_left_o),
    .right_o     (rx_right_o),
    .left_vld_o  (rx_left_vld_o),
    .right_vld_o (rx_right_vld_o)
  );

  asp_tx #(.SW(SAMPLE_W), .POS_W(POS_W)) u_tx (
    .clk_i      (bclk_i),
    .rst_ni     (rst_ni),
    .frame_i    (cfg.tx),
    .nbits_i    (cfg.lsb_bits),
    .ws_q_i     (ws_q),
    .pos_i      (pos),
    .last_pos_i (last_pos),
    .locked_i   (locked),
    .left_i     (tx_left_i),
    .right_i    (tx_right_i),
    .sdo_o      (sdo_o)
  );

endmodule

// File: tb/audio_serial_port_test.sv
module audio_serial_port_test;
  localparam int K_I2S = 0, K_MSB = 1, K_LSB = 2;
  localparam int NF = 4;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [6:0]  len;
    logic [19:0] seed;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{3'd0, 7'd32, 20'h3C5A1}, '{3'd0, 7'd24, 20'h81F27},
    '{3'd1, 7'd32, 20'h9E3B4}, '{3'd2, 7'd24, 20'h47AD9},
    '{3'd3, 7'd32, 20'hC1235}, '{3'd3, 7'd20, 20'h6B8F0},
    '{3'd4, 7'd32, 20'hF0A6D}, '{3'd4, 7'd20, 20'h2D94C},
    '{3'd5, 7'd24, 20'hA7713}, '{3'd6, 7'd32, 20'h5E0C8},
    '{3'd7, 7'd24, 20'hB39E6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic ws = 1'b0, sdi = 1'b0;
  logic [19:0] tl_i = '0, tr_i = '0;
  logic sdo, lvld, rvld;
  logic [19:0] rxl, rxr;

  always #10 clk = ~clk;

  audio_serial_port uut (
    .bclk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .ws_i(ws), .sdi_i(sdi),
    .tx_left_i(tl_i), .tx_right_i(tr_i), .sdo_o(sdo),
    .rx_left_o(rxl), .rx_right_o(rxr), .rx_left_vld_o(lvld), .rx_right_vld_o(rvld)
  );

  int checks = 0, fails = 0;
  int lcnt = 0, rcnt = 0, both_cnt = 0;
  logic [19:0] lcap [8];
  logic [19:0] rcap [8];
  int tx_bad, stab_bad, ones;
  logic tx_got, tx_exp;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      if (lvld) begin if (lcnt < 8) lcap[lcnt] = rxl; lcnt++; end
      if (rvld) begin if (rcnt < 8) rcap[rcnt] = rxr; rcnt++; end
      if (lvld && rvld) both_cnt++;
    end
  end

  function automatic int txk(input logic [2:0] f);
    return (f == 3'd0) ? K_I2S : (f < 3'd4) ? K_LSB : K_MSB;
  endfunction
  function automatic int rxk(input logic [2:0] f);
    return (f == 3'd0) ? K_I2S : (f == 3'd4) ? K_MSB : K_LSB;
  endfunction
  function automatic int nb(input logic [2:0] f);
    return (f[1:0] == 2'd1) ? 16 : (f[1:0] == 2'd2) ? 18 : 20;
  endfunction

  function automatic logic [19:0] tlw(input logic [19:0] s, input int f);
    return 20'(s * (f + 5)) ^ 20'h5A3C7;
  endfunction
  function automatic logic [19:0] trw(input logic [19:0] s, input int f);
    return 20'(s + f * 20'h2B1D9) ^ 20'hF0F0F;
  endfunction
  function automatic logic [19:0] rlw(input logic [19:0] s, input int f);
    return 20'(s * 3 + f * 20'h1F3E7);
  endfunction
  function automatic logic [19:0] rrw(input logic [19:0] s, input int f);
    return ~rlw(s, f) ^ 20'(f * 7);
  endfunction

  function automatic logic [19:0] sext(input logic [19:0] w, input int n);
    logic [19:0] r;
    for (int i = 0; i < 20; i++) r[i] = (i < n) ? w[i] : w[n-1];
    return r;
  endfunction

  // word region per framing; filler is 0/sign on transmit, toggling junk on receive
  function automatic logic ser_bit(input int kind, input int n, input int L, input int p,
                                   input logic [19:0] w, input bit junk);
    int idx;
    case (kind)
      K_I2S: return (p >= 1 && p <= 20) ? w[20-p] : (junk ? 1'(p & 1) : 1'b0);
      K_MSB: return (p < 20) ? w[19-p] : (junk ? 1'(p & 1) : 1'b0);
      default: begin
        idx = L - 1 - p;
        return (idx < n) ? w[idx] : (junk ? 1'(p & 1) : w[n-1]);
      end
    endcase
  endfunction

  task automatic do_reset(input logic ws_idle);
    @(negedge clk);
    rst_n = 1'b0; ws = ws_idle; sdi = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic w, input logic d, input logic e, input bit chk);
    logic a;
    @(negedge clk);
    #2; ws = w; sdi = d;
    #5; a = sdo;
    if (a) ones++;
    if (chk && a !== e) begin
      if (tx_bad == 0) begin tx_got = a; tx_exp = e; end
      tx_bad++;
    end
    @(posedge clk);
    #2;
    if (chk && sdo !== a) stab_bad++;
  endtask

  task automatic run_vec(input logic [2:0] f_, input int L, input logic [19:0] s);
    logic wl;
    int tk, rk, n, exp_l;
    string ttag, rtag;
    bit ok;
    tk = txk(f_); rk = rxk(f_); n = nb(f_);
    wl = (f_ == 3'd0) ? 1'b0 : 1'b1;
    ttag = (f_ >= 3'd5) ? "R1/R11/R7" : (tk == K_LSB) ? "R1/R11/R6" : "R1/R11/R5";
    rtag = (f_ >= 3'd5) ? "R7" : (rk == K_I2S) ? "R2" : (rk == K_MSB) ? "R4" : "R3";
    fmt = f_;
    tl_i = tlw(s, 0); tr_i = trw(s, 0);
    do_reset(~wl);
    lcnt = 0; rcnt = 0; both_cnt = 0; tx_bad = 0; stab_bad = 0; ones = 0;
    repeat (3) send_bit(~wl, 1'b0, 1'b0, 1'b0);
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < L; p++) begin
        if (p == L / 2) tl_i = tlw(s, f + 1);
        send_bit(wl, ser_bit(rk, n, L, p, rlw(s, f), 1'b1),
                 ser_bit(tk, n, L, p, tlw(s, f), 1'b0), f >= 1);
      end
      for (int p = 0; p < L; p++) begin
        if (p == L / 2) tr_i = trw(s, f + 1);
        send_bit(~wl, ser_bit(rk, n, L, p, rrw(s, f), 1'b1),
                 ser_bit(tk, n, L, p, trw(s, f), 1'b0), f >= 1);
      end
    end
    for (int p = 0; p < L; p++) send_bit(wl, 1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #5;
    check(tx_bad == 0, ttag, $sformatf("fmt=%0d L=%0d tx bits wrong=%0d first", f_, L, tx_bad),
          {31'd0, tx_got}, {31'd0, tx_exp});
    check(stab_bad == 0, "R10", $sformatf("fmt=%0d sdo moved at rising edge", f_), stab_bad, 0);
    ok = 1'b1;
    for (int f = 0; f < NF; f++) begin
      if (lcap[f] !== ((rk == K_LSB) ? sext(rlw(s, f), n) : rlw(s, f))) begin
        if (ok) check(1'b0, rtag, $sformatf("fmt=%0d L=%0d left word %0d", f_, L, f),
                      {12'd0, lcap[f]}, {12'd0, (rk == K_LSB) ? sext(rlw(s, f), n) : rlw(s, f)});
        ok = 1'b0;
      end
    end
    if (ok) check(1'b1, rtag, "left words", 0, 0);
    ok = 1'b1;
    for (int f = 0; f < NF; f++) begin
      if (rcap[f] !== ((rk == K_LSB) ? sext(rrw(s, f), n) : rrw(s, f))) begin
        if (ok) check(1'b0, rtag, $sformatf("fmt=%0d L=%0d right word %0d", f_, L, f),
                      {12'd0, rcap[f]}, {12'd0, (rk == K_LSB) ? sext(rrw(s, f), n) : rrw(s, f)});
        ok = 1'b0;
      end
    end
    if (ok) check(1'b1, rtag, "right words", 0, 0);
    exp_l = (rk == K_LSB) ? NF : NF + 1;
    check(lcnt == exp_l && rcnt == NF, "R8/R9",
          $sformatf("fmt=%0d strobe counts left=%0d right=%0d", f_, lcnt, rcnt),
          lcnt * 256 + rcnt, exp_l * 256 + NF);
    check(both_cnt == 0, "R8", "left and right strobes together", both_cnt, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    summary();
  end

  initial begin
    // R9: reset state
    #5;
    check({sdo, lvld, rvld, rxl, rxr} == '0, "R9", "outputs in reset",
          {29'd0, sdo, lvld, rvld}, 0);
    for (int i = 0; i < 11; i++) run_vec(VECS[i].fmt, int'(VECS[i].len), VECS[i].seed);

    // R9: one word-select change only, output must stay quiet
    fmt = 3'd4; tl_i = '1; tr_i = '1;
    do_reset(1'b0);
    ones = 0; tx_bad = 0; stab_bad = 0;
    repeat (3) send_bit(1'b0, 1'b0, 1'b0, 1'b0);
    for (int p = 0; p < 32; p++) send_bit(1'b1, 1'b1, 1'b0, 1'b0);
    check(ones == 0, "R9", "sdo ones before slot length known", ones, 0);
    summary();
  end

endmodule